// File: doc/BRIEF.md
# Two-Wire Controller Status and Interrupt Unit

This block keeps the ten status flags of a two-wire serial controller and drives one interrupt line from them. The byte engine, which does the bit shifting and drives the bus pins, reports single-cycle events to the block. These events cover the start of a frame, a STOP, a received byte, a transmit byte moved into the shifter, a shifter with no data to send, a NACK, lost arbitration, an own-address match, a general-call match with its direction bit, and controller enable. The block also watches the register bus for three accesses: status reads, receive-holding reads and transmit-holding writes. Several flags clear as a side effect of these accesses.

A small phase machine tracks whether a transfer is in progress. Its three states are PH_OFF (after reset, before enable), PH_IDLE (transfer complete, bit 0 high) and PH_FRAME (transfer in progress, bit 0 low). It has three transitions. Any state goes to PH_IDLE on enable, STOP, NACK or lost arbitration. PH_OFF or PH_IDLE goes to PH_FRAME on a frame start with none of those events present. Otherwise the state holds.

Software sets bits of an interrupt mask by writing ones to an enable register and clears them by writing ones to a disable register. The interrupt is raised whenever a status bit and its mask bit are both high.

Top module: `tws_status_unit`

## Requirements
- R1: After reset, the status word, the mask, the interrupt and the automatic STOP request are all zero.
- R2: Status bit 0 (transfer complete) clears on a frame start. It sets on enable, STOP, NACK or lost arbitration, and any of these wins over a start in the same cycle.
- R3: Bit 1 (receive ready) sets on a received byte and clears on a read of offset 0x30. A received byte wins over a read in the same cycle.
- R4: Bit 2 (transmit ready) clears on a write to offset 0x34. It sets on a shifter load, on enable or on a NACK, and a set wins over the write in the same cycle.
- R5: Bit 6 (overrun) sets when a byte is received while bit 1 is already high.
- R6: Bit 7 (underrun) sets on an underrun event. When the master-mode input is high, auto_stop_req pulses high in the cycle after that event; in slave mode it stays low.
- R7: Bits 4 (address match), 5 (general call), 6 and 7 clear on a status read at offset 0x20 only if bit 0 was already 1 at that read. A set event in the same cycle wins over the clear.
- R8: Bit 8 (NACK) sets in the same cycle that bits 0 and 2 set, and clears on any status read at 0x20. A new NACK wins over the clear.
- R9: Bit 9 (arbitration lost) sets in the same cycle as bit 0 and clears on any status read at 0x20.
- R10: Bit 3 (slave read direction) takes the direction input on each own-address match, where 1 means a read access and 0 a write access. It holds its value otherwise.
- R11: A write to 0x24 sets every mask bit written as 1, and a write to 0x28 clears every mask bit written as 1. Bits written as 0 are unchanged, and no other address changes the mask.
- R12: irq is high exactly when some status bit and the same mask bit are both 1. It follows the status and mask of the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_enable | input | 1 | Controller enable pulse |
| is_master | input | 1 | High while the controller acts as bus master |
| ev_start | input | 1 | Frame start (master begins frame or slave sees START) |
| ev_stop | input | 1 | STOP sent or received with holding and shifter empty |
| ev_rx_byte | input | 1 | Received byte placed in receive holding register |
| ev_tx_load | input | 1 | Transmit holding byte moved into shifter |
| ev_underrun | input | 1 | Shifter needed data but none was held |
| ev_nack | input | 1 | Far end did not acknowledge |
| ev_arb_lost | input | 1 | Another master won arbitration |
| ev_addr_match | input | 1 | Received address matched own address |
| ev_gcall_match | input | 1 | Received address matched general call |
| ev_dir_read | input | 1 | Direction bit of the matched access, 1 = read |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 10 | Write data for the mask registers |
| status | output | 10 | Status word |
| mask | output | 10 | Interrupt mask readback |
| irq | output | 1 | Interrupt request |
| auto_stop_req | output | 1 | One-cycle request to issue STOP after a master underrun |

## Verification
The main collision is a register-bus access that clears a flag landing in the same cycle as an engine event that sets it. Examples are a status read coinciding with an address match or a NACK, a receive-holding read coinciding with a received byte, and a transmit-holding write coinciding with a shifter load. The bench forces these in directed sequences and also lets them arise from random traffic in which reads and events overlap freely. Every cycle, a reference model built from the requirements decides the outcome: the set wins. A second pairing is a frame start arriving together with a NACK or a STOP, and that case is judged the same way against bit 0.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int TW_NFLAGS = 10;

    // status bit positions (fixed by software decoding)
    localparam int B_DONE  = 0;
    localparam int B_RXRDY = 1;
    localparam int B_TXRDY = 2;
    localparam int B_SRD   = 3;
    localparam int B_SACC  = 4;
    localparam int B_GACC  = 5;
    localparam int B_OVR   = 6;
    localparam int B_UNR   = 7;
    localparam int B_NACK  = 8;
    localparam int B_ARB   = 9;

    localparam logic [7:0] DEF_OFS_STAT = 8'h20;
    localparam logic [7:0] DEF_OFS_IEN  = 8'h24;
    localparam logic [7:0] DEF_OFS_IDIS = 8'h28;
    localparam logic [7:0] DEF_OFS_RX   = 8'h30;
    localparam logic [7:0] DEF_OFS_TX   = 8'h34;

    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_IDLE  = 2'd1,
        PH_FRAME = 2'd2
    } phase_t;

endpackage

// File: rtl/tws_phase_fsm.sv
module tws_phase_fsm
    import tws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_idle,
    input  logic go_frame,
    output logic done
);

    phase_t state_q;
    phase_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_OFF: begin
                if (go_idle)       state_d = PH_IDLE;
                else if (go_frame) state_d = PH_FRAME;
            end
            PH_IDLE: begin
                if (go_frame && !go_idle) state_d = PH_FRAME;
            end
            PH_FRAME: begin
                if (go_idle) state_d = PH_IDLE;
            end
            default: state_d = PH_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            PH_IDLE: done = 1'b1;
            default: done = 1'b0;
        endcase
    end

endmodule

// File: rtl/tws_flag_bank.sv
module tws_flag_bank #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_v,
    input  logic [WIDTH-1:0] clr_v,
    output logic [WIDTH-1:0] flags
);

    // one sticky cell per flag; set has priority over clear
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (set_v[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_v[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tws_irq_mask.sv
module tws_irq_mask #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             dis_wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] mask,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (en_wr) begin
            mask <= mask | wdata;
        end else if (dis_wr) begin
            mask <= mask & ~wdata;
        end
    end

    assign irq = |(status & mask);

endmodule

// File: rtl/tws_status_unit.sv
module tws_status_unit
    import tws_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] OFS_STAT = DEF_OFS_STAT,
    parameter logic [7:0] OFS_IEN  = DEF_OFS_IEN,
    parameter logic [7:0] OFS_IDIS = DEF_OFS_IDIS,
    parameter logic [7:0] OFS_RX   = DEF_OFS_RX,
    parameter logic [7:0] OFS_TX   = DEF_OFS_TX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_enable,
    input  logic                 is_master,
    input  logic                 ev_start,
    input  logic                 ev_stop,
    input  logic                 ev_rx_byte,
    input  logic                 ev_tx_load,
    input  logic                 ev_underrun,
    input  logic                 ev_nack,
    input  logic                 ev_arb_lost,
    input  logic                 ev_addr_match,
    input  logic                 ev_gcall_match,
    input  logic                 ev_dir_read,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [TW_NFLAGS-1:0] bus_wdata,
    output logic [TW_NFLAGS-1:0] status,
    output logic [TW_NFLAGS-1:0] mask,
    output logic                 irq,
    output logic                 auto_stop_req
);

    localparam int NB = TW_NFLAGS - 1;   // flags held in the bank (bits 1..9)

    logic rd_stat, rd_rx, wr_tx, wr_ien, wr_idis;
    logic done, go_idle, cond_clr;
    logic [NB-1:0] set_v, clr_v, bank_q;
    logic [TW_NFLAGS-1:0] set_full, clr_full;

    assign rd_stat = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));
    assign rd_rx   = bus_rd && (bus_addr == ADDR_W'(OFS_RX));
    assign wr_tx   = bus_wr && (bus_addr == ADDR_W'(OFS_TX));
    assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(OFS_IEN));
    assign wr_idis = bus_wr && (bus_addr == ADDR_W'(OFS_IDIS));

    assign go_idle = ctrl_enable || ev_stop || ev_nack || ev_arb_lost;

    tws_phase_fsm u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_idle  (go_idle),
        .go_frame (ev_start),
        .done     (done)
    );

    // access and error flags clear on status read only once the transfer is done
    assign cond_clr = rd_stat && done;

    always_comb begin
        set_full = '0;
        clr_full = '0;
        set_full[B_RXRDY] = ev_rx_byte;
        clr_full[B_RXRDY] = rd_rx;
        set_full[B_TXRDY] = ev_tx_load || ctrl_enable || ev_nack;
        clr_full[B_TXRDY] = wr_tx;
        set_full[B_SRD]   = ev_addr_match && ev_dir_read;
        clr_full[B_SRD]   = ev_addr_match && !ev_dir_read;
        set_full[B_SACC]  = ev_addr_match;
        clr_full[B_SACC]  = cond_clr;
        set_full[B_GACC]  = ev_gcall_match;
        clr_full[B_GACC]  = cond_clr;
        set_full[B_OVR]   = ev_rx_byte && status[B_RXRDY];
        clr_full[B_OVR]   = cond_clr;
        set_full[B_UNR]   = ev_underrun;
        clr_full[B_UNR]   = cond_clr;
        set_full[B_NACK]  = ev_nack;
        clr_full[B_NACK]  = rd_stat;
        set_full[B_ARB]   = ev_arb_lost;
        clr_full[B_ARB]   = rd_stat;
    end

    assign set_v = set_full[TW_NFLAGS-1:1];
    assign clr_v = clr_full[TW_NFLAGS-1:1];

    tws_flag_bank #(.WIDTH(NB)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_v (set_v),
        .clr_v (clr_v),
        .flags (bank_q)
    );

    assign status = {bank_q, done};

    tws_irq_mask #(.WIDTH(TW_NFLAGS)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (wr_ien),
        .dis_wr (wr_idis),
        .wdata  (bus_wdata),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_stop_req <= 1'b0;
        end else begin
            auto_stop_req <= ev_underrun && is_master;
        end
    end

    // unused low bits of the set/clear vectors for bit 0 (driven by the phase machine)
    logic unused_ok;
    assign unused_ok = &{1'b0, set_full[0], clr_full[0]};

endmodule

// File: rtl/tws_status_chk.sv
module tws_status_chk
    import tws_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] OFS_STAT = DEF_OFS_STAT,
    parameter logic [7:0] OFS_IEN  = DEF_OFS_IEN,
    parameter logic [7:0] OFS_TX   = DEF_OFS_TX
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ctrl_enable,
    input logic                 is_master,
    input logic                 ev_start,
    input logic                 ev_stop,
    input logic                 ev_rx_byte,
    input logic                 ev_tx_load,
    input logic                 ev_underrun,
    input logic                 ev_nack,
    input logic                 ev_arb_lost,
    input logic                 ev_addr_match,
    input logic                 ev_dir_read,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [TW_NFLAGS-1:0] bus_wdata,
    input logic [TW_NFLAGS-1:0] status,
    input logic [TW_NFLAGS-1:0] mask,
    input logic                 auto_stop_req
);

    assert_frame_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_start && !(ev_stop || ev_nack || ev_arb_lost || ctrl_enable)) |=> !status[B_DONE]);

    assert_rx_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_byte |=> status[B_RXRDY]);

    assert_tx_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_TX) && !(ev_tx_load || ctrl_enable || ev_nack))
        |=> !status[B_TXRDY]);

    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_byte && status[B_RXRDY]) |=> status[B_OVR]);

    assert_autostop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_underrun && is_master) |=> (auto_stop_req && status[B_UNR]));

    assert_keep_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_STAT) && !status[B_DONE] && status[B_SACC])
        |=> status[B_SACC]);

    assert_nack_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> (status[B_DONE] && status[B_TXRDY] && status[B_NACK]));

    assert_arb_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> (status[B_DONE] && status[B_ARB]));

    assert_direction_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_addr_match |=> (status[B_SRD] == $past(ev_dir_read)));

    assert_mask_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_IEN)) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

endmodule

bind tws_status_unit tws_status_chk #(
    .ADDR_W   (ADDR_W),
    .OFS_STAT (OFS_STAT),
    .OFS_IEN  (OFS_IEN),
    .OFS_TX   (OFS_TX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_enable   (ctrl_enable),
    .is_master     (is_master),
    .ev_start      (ev_start),
    .ev_stop       (ev_stop),
    .ev_rx_byte    (ev_rx_byte),
    .ev_tx_load    (ev_tx_load),
    .ev_underrun   (ev_underrun),
    .ev_nack       (ev_nack),
    .ev_arb_lost   (ev_arb_lost),
    .ev_addr_match (ev_addr_match),
    .ev_dir_read   (ev_dir_read),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .status        (status),
    .mask          (mask),
    .auto_stop_req (auto_stop_req)
);

// File: tb/test_tws_status_unit.sv
`timescale 1ns/1ps
module test_tws_status_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic e_en, e_mst, e_start, e_stop, e_rx, e_ld, e_un, e_nack, e_arb, e_am, e_gc, e_dir;
    logic b_rd, b_wr;
    logic [7:0] b_addr;
    logic [9:0] b_wd;
    logic [9:0] status, mask;
    logic irq, auto_stop_req;

    tws_status_unit i_tws_status_unit (
        .clk(clk), .rst_n(rst_n), .ctrl_enable(e_en), .is_master(e_mst),
        .ev_start(e_start), .ev_stop(e_stop), .ev_rx_byte(e_rx), .ev_tx_load(e_ld),
        .ev_underrun(e_un), .ev_nack(e_nack), .ev_arb_lost(e_arb),
        .ev_addr_match(e_am), .ev_gcall_match(e_gc), .ev_dir_read(e_dir),
        .bus_rd(b_rd), .bus_wr(b_wr), .bus_addr(b_addr), .bus_wdata(b_wd),
        .status(status), .mask(mask), .irq(irq), .auto_stop_req(auto_stop_req)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [9:0] x_s = '0;
    logic [9:0] x_m = '0;
    logic x_as = 1'b0;

    function automatic string tag_of(input int b);
        case (b)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R10";
            4, 5: return "R7";
            6: return "R5";
            7: return "R6";
            8: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [9:0] next_status(input logic [9:0] s);
        logic [9:0] n;
        logic rd_s, rd_r, wr_t, cc;
        rd_s = b_rd && b_addr == 8'h20;
        rd_r = b_rd && b_addr == 8'h30;
        wr_t = b_wr && b_addr == 8'h34;
        cc   = rd_s && s[0];
        n[0] = (e_stop || e_nack || e_arb || e_en) ? 1'b1 : e_start ? 1'b0 : s[0];
        n[1] = e_rx ? 1'b1 : rd_r ? 1'b0 : s[1];
        n[2] = (e_ld || e_en || e_nack) ? 1'b1 : wr_t ? 1'b0 : s[2];
        n[3] = e_am ? e_dir : s[3];
        n[4] = e_am ? 1'b1 : cc ? 1'b0 : s[4];
        n[5] = e_gc ? 1'b1 : cc ? 1'b0 : s[5];
        n[6] = (e_rx && s[1]) ? 1'b1 : cc ? 1'b0 : s[6];
        n[7] = e_un ? 1'b1 : cc ? 1'b0 : s[7];
        n[8] = e_nack ? 1'b1 : rd_s ? 1'b0 : s[8];
        n[9] = e_arb ? 1'b1 : rd_s ? 1'b0 : s[9];
        return n;
    endfunction

    function automatic logic [9:0] next_mask(input logic [9:0] m);
        if (b_wr && b_addr == 8'h24) return m | b_wd;
        if (b_wr && b_addr == 8'h28) return m & ~b_wd;
        return m;
    endfunction

    task automatic compare_all();
        for (int b = 0; b < 10; b++) begin
            n_cmp++;
            if (status[b] !== x_s[b]) begin
                n_bad++;
                $display("FAIL %s status[%0d] actual=%b expected=%b at %0t", tag_of(b), b, status[b], x_s[b], $time);
            end
        end
        n_cmp++;
        if (mask !== x_m) begin
            n_bad++;
            $display("FAIL R11 mask actual=%h expected=%h", mask, x_m);
        end
        n_cmp++;
        if (irq !== |(x_s & x_m)) begin
            n_bad++;
            $display("FAIL R12 irq actual=%b expected=%b", irq, |(x_s & x_m));
        end
        n_cmp++;
        if (auto_stop_req !== x_as) begin
            n_bad++;
            $display("FAIL R6 auto_stop_req actual=%b expected=%b", auto_stop_req, x_as);
        end
    endtask

    task automatic clr_in();
        {e_en, e_start, e_stop, e_rx, e_ld, e_un, e_nack, e_arb, e_am, e_gc, e_dir} = '0;
        b_rd = 1'b0; b_wr = 1'b0; b_addr = 8'h00; b_wd = '0;
    endtask

    // inputs are set at the falling edge; outputs are judged 2 ns after the rising edge
    task automatic cycle();
        logic [9:0] ns, nm;
        logic nas;
        ns  = next_status(x_s);
        nm  = next_mask(x_m);
        nas = e_un && e_mst;
        @(posedge clk);
        #2;
        x_s = ns; x_m = nm; x_as = nas;
        compare_all();
        @(negedge clk);
        clr_in();
    endtask

    task automatic stat_read();
        b_rd = 1'b1; b_addr = 8'h20; cycle();
    endtask

    initial begin : watchdog
        #1500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        logic [7:0] alist [7];
        alist = '{8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h10};
        void'($urandom(32'h1C5A));
        e_mst = 1'b1;
        clr_in();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        n_cmp++;
        if (status !== 10'h0 || mask !== 10'h0 || irq !== 1'b0 || auto_stop_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset actual=%h/%h/%b/%b expected=0", status, mask, irq, auto_stop_req);
        end

        // R2/R4 enable, R10 read access, R7 no clear while busy, then clear once done
        e_en = 1'b1; cycle();
        e_am = 1'b1; e_dir = 1'b1; e_start = 1'b1; cycle();
        stat_read();                         // R7: bit 0 low, bit 4 must survive
        e_stop = 1'b1; cycle();
        stat_read();                         // R7: bit 0 high, bit 4 clears
        // R2/R8: start and NACK together; NACK wins
        e_start = 1'b1; e_nack = 1'b1; cycle();
        // R8: new NACK wins over status read
        e_nack = 1'b1; b_rd = 1'b1; b_addr = 8'h20; cycle();
        stat_read();
        // R3/R5: two bytes then byte together with receive read
        e_rx = 1'b1; cycle();
        e_rx = 1'b1; cycle();
        e_rx = 1'b1; b_rd = 1'b1; b_addr = 8'h30; cycle();
        b_rd = 1'b1; b_addr = 8'h30; cycle();
        // R4: transmit write with and without a shifter load
        b_wr = 1'b1; b_addr = 8'h34; e_ld = 1'b1; cycle();
        b_wr = 1'b1; b_addr = 8'h34; cycle();
        // R6: underrun in master and slave mode
        e_un = 1'b1; cycle();
        cycle();
        e_mst = 1'b0; e_un = 1'b1; cycle();
        e_mst = 1'b1;
        // R7: general call set and clear request in one cycle while done
        e_gc = 1'b1; b_rd = 1'b1; b_addr = 8'h20; cycle();
        // R9: arbitration lost mid-frame
        e_start = 1'b1; cycle();
        e_arb = 1'b1; cycle();
        // R11/R12: mask writes, zeros ignored, other address ignored
        b_wr = 1'b1; b_addr = 8'h24; b_wd = 10'h3FF; cycle();
        b_wr = 1'b1; b_addr = 8'h28; b_wd = 10'h155; cycle();
        b_wr = 1'b1; b_addr = 8'h2C; b_wd = 10'h3FF; cycle();
        b_wr = 1'b1; b_addr = 8'h28; b_wd = 10'h2AA; cycle();

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            e_mst   = ($urandom % 4) != 0;
            e_en    = ($urandom % 40) == 0;
            e_start = ($urandom % 8) == 0;
            e_stop  = ($urandom % 8) == 0;
            e_rx    = ($urandom % 5) == 0;
            e_ld    = ($urandom % 6) == 0;
            e_un    = ($urandom % 12) == 0;
            e_nack  = ($urandom % 14) == 0;
            e_arb   = ($urandom % 16) == 0;
            e_am    = ($urandom % 10) == 0;
            e_gc    = ($urandom % 12) == 0;
            e_dir   = ($urandom % 2) == 0;
            case ($urandom % 3)
                0: begin b_rd = 1'b1; b_addr = alist[$urandom % 7]; end
                1: begin b_wr = 1'b1; b_addr = alist[$urandom % 7]; b_wd = 10'($urandom); end
                default: ;
            endcase
            cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule